// File: doc/BRIEF.md
# Parallel NOR Flash Command Interface

This block is a device-side model of the command front end of a word-wide parallel NOR flash. It samples the chip-enable, write-enable and output-enable strobes (all active low) together with the address and data buses on a system clock. It decodes the unlock-guarded command sequences for word program, sector erase, block erase and whole-array erase. It also holds a small array of words in flops and updates it when an operation completes.

A bus write lasts as long as both chip enable and write enable are low. The address is taken when the write opens and the data when it closes, so the strobe that moves last on the way down and first on the way up decides the timing. A completed sequence starts an internal operation that holds `busy` for a fixed number of clock cycles. During that time every write is ignored and reads return a status word instead of array contents. The array window is 2^ARR_W words. Sector and block sizes are set by parameters (2^SECT_W and 2^BLK_W words), and the defaults are scaled down so that the array stays small.

Top module: `nor_cmd_decoder`

## Requirements
- R1: The address of a bus write is captured in the first clock in which chip enable and write enable are both low. The data is the value present in the last clock in which both were low. Changes on either bus between those points have no effect.
- R2: `dq_oe` is high only while `ce_n` and `oe_n` are both low, and `dq_out` is zero whenever `dq_oe` is low. While idle, a read returns the array word addressed by `addr[ARR_W-1:0]`.
- R3: The writes AAh at 5555h, 55h at 2AAAh and A0h at 5555h, followed by a fourth write (target address, data), start a program. `busy` rises on the clock after the fourth write ends and stays high for exactly PROG_CYCLES cycles.
- R4: A program leaves the target word equal to its old value ANDed with the written data, so programming only clears bits.
- R5: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh followed by 30h at any address set to FFFFh every word whose index bits above SECT_W match that address. `busy` is held for ERASE_CYCLES cycles.
- R6: The same prefix followed by 50h erases every word whose index bits above BLK_W match the last address, with the same busy time as an erase.
- R7: The same prefix followed by 10h at address 5555h sets every word to FFFFh.
- R8: A write that does not match the expected step of a sequence (address compared on all bits, command on data bits 7:0) returns the decoder to idle. `busy` stays low and the array is unchanged.
- R9: While `busy` is high, all writes are ignored. No operation follows the current one, and the array sees only the running operation.
- R10: While busy, a read returns a status word. Bit 7 is the complement of bit 7 of the data being written (FFFFh for erases), bit 6 is the toggle bit, and every other bit is zero.
- R11: The toggle bit inverts at the end of every read made while busy, so two consecutive status reads differ in bit 6.
- R12: After reset, `busy` is low, the decoder is idle and every array word is FFFFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock on which the strobes are sampled |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address bus |
| dq_in | input | DATA_W | Data bus as driven by the host |
| dq_out | output | DATA_W | Data bus as driven by the device (zero when not driving) |
| dq_oe | output | 1 | High when the device drives the data bus |
| busy | output | 1 | High while an internal program or erase runs |

## Verification
On every cycle the assertions check that the output enable follows the read strobes, that an operation starts only on the clock after a write closes, that each busy period has one of the two legal lengths, that status bit 7 holds steady through a busy period, and that a new operation never starts straight after one ends. Capture timing when the strobes are skewed, the AND behaviour of programming, the extent of sector and block erases, aborted sequences and commands dropped while busy can only be shown by the bench scenarios, which compare the results against a word-level model of the array.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam logic [14:0] UNLOCK_ADDR_A = 15'h5555;
    localparam logic [14:0] UNLOCK_ADDR_B = 15'h2AAA;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
    localparam logic [7:0] CMD_WORD   = 8'hA0;
    localparam logic [7:0] CMD_ERASE  = 8'h80;
    localparam logic [7:0] CMD_SECT   = 8'h30;
    localparam logic [7:0] CMD_BLK    = 8'h50;
    localparam logic [7:0] CMD_ALL    = 8'h10;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_KEY1  = 3'd1,
        S_KEY2  = 3'd2,
        S_WORD  = 3'd3,
        S_EKEY0 = 3'd4,
        S_EKEY1 = 3'd5,
        S_EKEY2 = 3'd6
    } seq_e;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_BLK  = 2'd2,
        OP_ALL  = 2'd3
    } op_e;

endpackage

// File: rtl/fcd_strobe.sv
module fcd_strobe #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic              wr_end,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_end
);

    typedef struct packed {
        logic              wr_act;
        logic              rd_act;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } strobe_t;

    strobe_t st_d, st_q;
    logic    wr_now, rd_now;

    assign wr_now = !ce_n && !we_n;
    assign rd_now = !ce_n && !oe_n;

    always_comb begin
        st_d        = st_q;
        st_d.wr_act = wr_now;
        st_d.rd_act = rd_now;
        if (wr_now && !st_q.wr_act) begin
            st_d.addr = addr;
        end
        if (wr_now) begin
            st_d.data = dq_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_end  = st_q.wr_act && !wr_now;
    assign rd_end  = st_q.rd_act && !rd_now;
    assign wr_addr = st_q.addr;
    assign wr_data = st_q.data;

endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
    import fcd_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 16,
    parameter int ARR_W        = 6,
    parameter int PROG_CYCLES  = 20,
    parameter int ERASE_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_end,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_end,
    output logic              busy,
    output logic              commit,
    output op_e               op,
    output logic [ARR_W-1:0]  tgt_addr,
    output logic [DATA_W-1:0] tgt_data,
    output logic              toggle
);

    localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0]  PROG_LD  = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0]  ERASE_LD = CNT_W'(ERASE_CYCLES - 1);
    localparam logic [ADDR_W-1:0] ADR_A    = ADDR_W'(UNLOCK_ADDR_A);
    localparam logic [ADDR_W-1:0] ADR_B    = ADDR_W'(UNLOCK_ADDR_B);

    typedef struct packed {
        seq_e              step;
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        op_e               op;
        logic [ARR_W-1:0]  tgt_addr;
        logic [DATA_W-1:0] tgt_data;
        logic              tog;
    } seq_t;

    seq_t       sq_d, sq_q;
    logic       at_a, at_b, launch;
    logic [7:0] cmd;
    op_e        launch_op;

    assign at_a = (wr_addr == ADR_A);
    assign at_b = (wr_addr == ADR_B);
    assign cmd  = wr_data[7:0];

    always_comb begin
        sq_d      = sq_q;
        commit    = 1'b0;
        launch    = 1'b0;
        launch_op = OP_PROG;
        if (sq_q.busy) begin
            if (rd_end) begin
                sq_d.tog = ~sq_q.tog;
            end
            if (sq_q.cnt == '0) begin
                sq_d.busy = 1'b0;
                commit    = 1'b1;
            end else begin
                sq_d.cnt = sq_q.cnt - 1'b1;
            end
        end else if (wr_end) begin
            sq_d.step = S_IDLE;
            case (sq_q.step)
                S_IDLE:  if (at_a && cmd == KEY_FIRST)  sq_d.step = S_KEY1;
                S_KEY1:  if (at_b && cmd == KEY_SECOND) sq_d.step = S_KEY2;
                S_KEY2: begin
                    if (at_a && cmd == CMD_WORD)       sq_d.step = S_WORD;
                    else if (at_a && cmd == CMD_ERASE) sq_d.step = S_EKEY0;
                end
                S_WORD: begin
                    launch    = 1'b1;
                    launch_op = OP_PROG;
                end
                S_EKEY0: if (at_a && cmd == KEY_FIRST)  sq_d.step = S_EKEY1;
                S_EKEY1: if (at_b && cmd == KEY_SECOND) sq_d.step = S_EKEY2;
                S_EKEY2: begin
                    if (cmd == CMD_SECT) begin
                        launch    = 1'b1;
                        launch_op = OP_SECT;
                    end else if (cmd == CMD_BLK) begin
                        launch    = 1'b1;
                        launch_op = OP_BLK;
                    end else if (at_a && cmd == CMD_ALL) begin
                        launch    = 1'b1;
                        launch_op = OP_ALL;
                    end
                end
                default: sq_d.step = S_IDLE;
            endcase
        end
        if (launch) begin
            sq_d.busy     = 1'b1;
            sq_d.op       = launch_op;
            sq_d.cnt      = (launch_op == OP_PROG) ? PROG_LD : ERASE_LD;
            sq_d.tgt_addr = wr_addr[ARR_W-1:0];
            sq_d.tgt_data = (launch_op == OP_PROG) ? wr_data : '1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign busy     = sq_q.busy;
    assign op       = sq_q.op;
    assign tgt_addr = sq_q.tgt_addr;
    assign tgt_data = sq_q.tgt_data;
    assign toggle   = sq_q.tog;

endmodule

// File: rtl/fcd_array.sv
module fcd_array
    import fcd_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ARR_W  = 6,
    parameter int SECT_W = 3,
    parameter int BLK_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  op_e               op,
    input  logic [ARR_W-1:0]  tgt_addr,
    input  logic [DATA_W-1:0] tgt_data,
    input  logic [ARR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ARR_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        localparam logic [ARR_W-1:0] IDX = ARR_W'(i);
        logic word_hit, sect_hit, blk_hit, wipe;

        assign word_hit = (IDX == tgt_addr);
        assign sect_hit = (IDX[ARR_W-1:SECT_W] == tgt_addr[ARR_W-1:SECT_W]);
        assign blk_hit  = (IDX[ARR_W-1:BLK_W] == tgt_addr[ARR_W-1:BLK_W]);
        assign wipe     = (op == OP_ALL) || (op == OP_SECT && sect_hit) || (op == OP_BLK && blk_hit);

        assign mem_d[i] = !commit                      ? mem_q[i] :
                          (op == OP_PROG && word_hit)  ? (mem_q[i] & tgt_data) :
                          wipe                         ? '1 :
                                                         mem_q[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                mem_q[k] <= '1;
            end
        end else begin
            for (int k = 0; k < DEPTH; k++) begin
                mem_q[k] <= mem_d[k];
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 16,
    parameter int ARR_W        = 6,
    parameter int SECT_W       = 3,
    parameter int BLK_W        = 5,
    parameter int PROG_CYCLES  = 20,
    parameter int ERASE_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              busy
);

    logic              wr_end, rd_end, commit, toggle;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data, tgt_data, rd_data, status;
    logic [ARR_W-1:0]  tgt_addr;
    op_e               op;

    fcd_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .addr    (addr),
        .dq_in   (dq_in),
        .wr_end  (wr_end),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_end  (rd_end)
    );

    fcd_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARR_W(ARR_W),
        .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_end   (wr_end),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_end   (rd_end),
        .busy     (busy),
        .commit   (commit),
        .op       (op),
        .tgt_addr (tgt_addr),
        .tgt_data (tgt_data),
        .toggle   (toggle)
    );

    fcd_array #(.DATA_W(DATA_W), .ARR_W(ARR_W), .SECT_W(SECT_W), .BLK_W(BLK_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .op       (op),
        .tgt_addr (tgt_addr),
        .tgt_data (tgt_data),
        .rd_addr  (addr[ARR_W-1:0]),
        .rd_data  (rd_data)
    );

    always_comb begin
        status    = '0;
        status[7] = ~tgt_data[7];
        status[6] = toggle;
    end

    assign dq_oe  = !ce_n && !oe_n;
    assign dq_out = !dq_oe ? '0 : (busy ? status : rd_data);

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
    parameter int PROG_CYCLES  = 20,
    parameter int ERASE_CYCLES = 40
) (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic we_n,
    input logic oe_n,
    input logic dq_oe,
    input logic stat7,
    input logic busy
);

    int unsigned run_q;
    logic        wr_now;

    assign wr_now = !ce_n && !we_n;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            run_q <= 0;
        end else begin
            run_q <= run_q + 1;
        end
    end

    // R2: no drive unless both read strobes are low
    assert_no_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> !dq_oe);

    // R3: an operation starts only on the clock after a write closes
    assert_start_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(wr_now, 2) && !$past(wr_now, 1)));

    // R3: busy period has one of the two legal lengths
    assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == PROG_CYCLES || run_q == ERASE_CYCLES));

    // R10: status bit 7 holds across a busy period
    assert_stat7_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && dq_oe && $past(dq_oe)) |-> $stable(stat7));

    // R9: commands written during busy never chain into a new operation
    assert_no_chain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> !busy);

endmodule

bind nor_cmd_decoder fcd_checker #(
    .PROG_CYCLES(PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
) u_fcd_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .ce_n  (ce_n),
    .we_n  (we_n),
    .oe_n  (oe_n),
    .dq_oe (dq_oe),
    .stat7 (dq_out[7]),
    .busy  (busy)
);

// File: tb/nor_cmd_decoder_test.sv
module nor_cmd_decoder_test;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int ARR_W  = 6;
    localparam int SECT_W = 3;
    localparam int BLK_W  = 5;
    localparam int PROG_C = 20;
    localparam int ERAS_C = 40;
    localparam int DEPTH  = 1 << ARR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] dq_in = '0;
    logic [DATA_W-1:0] dq_out;
    logic              dq_oe;
    logic              busy;

    int n_tests = 0;
    int n_fail  = 0;
    logic [DATA_W-1:0] exp_mem [DEPTH];

    always #4 clk = ~clk;

    nor_cmd_decoder #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARR_W(ARR_W), .SECT_W(SECT_W),
        .BLK_W(BLK_W), .PROG_CYCLES(PROG_C), .ERASE_CYCLES(ERAS_C)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .busy(busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] model_read(input logic [ADDR_W-1:0] a);
        return exp_mem[a[ARR_W-1:0]];
    endfunction

    task automatic model_prog(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        exp_mem[a[ARR_W-1:0]] = exp_mem[a[ARR_W-1:0]] & d;
    endtask

    task automatic model_wipe(input int low_bits, input logic [ADDR_W-1:0] a);
        for (int i = 0; i < DEPTH; i++) begin
            if ((i >> low_bits) == (int'(a[ARR_W-1:0]) >> low_bits)) exp_mem[i] = '1;
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        addr = a; dq_in = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d,
                            output logic oe);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        #1;
        d = dq_out; oe = dq_oe;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic unlock(input logic [7:0] c);
        bus_write(16'h5555, 16'h00AA);
        bus_write(16'h2AAA, 16'h0055);
        bus_write(16'h5555, {8'h00, c});
    endtask

    task automatic count_busy(output int n);
        n = 0;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            if (busy) n++;
            else break;
        end
    endtask

    task automatic verify(input string req, input logic [ADDR_W-1:0] a);
        logic [DATA_W-1:0] d;
        logic oe;
        bus_read(a, d, oe);
        check(req, d, model_read(a));
    endtask

    task automatic do_program(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        int n;
        unlock(8'hA0);
        bus_write(a, d);
        count_busy(n);
        check("R3 program busy length", n, PROG_C);
        model_prog(a, d);
        verify("R4 program result", a);
    endtask

    task automatic do_erase(input logic [7:0] c, input logic [ADDR_W-1:0] a);
        int n;
        unlock(8'h80);
        bus_write(16'h5555, 16'h00AA);
        bus_write(16'h2AAA, 16'h0055);
        bus_write(a, {8'h00, c});
        count_busy(n);
        check("R5/R6/R7 erase busy length", n, ERAS_C);
        if (c == 8'h30) model_wipe(SECT_W, a);
        else if (c == 8'h50) model_wipe(BLK_W, a);
        else model_wipe(ARR_W, a);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] d, d2;
        logic oe;
        int n;
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        @(negedge clk);
        check("R12 busy after reset", busy, 0);
        verify("R12 erased after reset", 16'h0000);
        verify("R12 erased after reset", 16'h003F);

        // R2: output enable gating
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b0; #1;
        check("R2 no drive with ce_n high", {dq_oe, dq_out}, 0);
        ce_n = 1'b0; oe_n = 1'b1; #1;
        check("R2 no drive with oe_n high", {dq_oe, dq_out}, 0);
        ce_n = 1'b1;
        bus_read(16'h0005, d, oe);
        check("R2 drive during read", oe, 1);

        // R3/R4 directed program
        do_program(16'h0005, 16'h1234);
        do_program(16'h0005, 16'hF0F0);

        // R1: skewed strobes, bus changes inside the write
        unlock(8'hA0);
        @(negedge clk); addr = 16'h0009; dq_in = 16'hAAAA; ce_n = 1'b0;
        @(negedge clk); we_n = 1'b0;
        @(negedge clk); addr = 16'h0011; dq_in = 16'h0F0F;
        @(negedge clk); dq_in = 16'h5A5A;
        @(negedge clk); we_n = 1'b1; dq_in = 16'h0000; addr = 16'h0022;
        @(negedge clk); ce_n = 1'b1;
        count_busy(n);
        check("R1 skewed write starts program", n, PROG_C - 1);
        model_prog(16'h0009, 16'h5A5A);
        verify("R1 address at open, data at close", 16'h0009);
        verify("R1 other address untouched", 16'h0011);

        // R10/R11: status reads while busy
        unlock(8'hA0);
        bus_write(16'h0030, 16'h0F0F);
        bus_read(16'h0030, d, oe);
        bus_read(16'h0030, d2, oe);
        check("R10 status bit 7 inverted", d[7], 1);
        check("R10 status other bits zero", d & 16'hFF3F, 0);
        check("R11 toggle flips between reads", d[6] ^ d2[6], 1);
        check("R10 still busy", busy, 1);
        count_busy(n);
        model_prog(16'h0030, 16'h0F0F);
        verify("R4 program after status", 16'h0030);

        // R8: abort on wrong step
        bus_write(16'h5555, 16'h00AA);
        bus_write(16'h2AAA, 16'h0055);
        bus_write(16'h1555, 16'h00A0);
        bus_write(16'h0031, 16'h0000);
        @(negedge clk);
        check("R8 no busy after abort", busy, 0);
        verify("R8 array untouched", 16'h0031);

        // R9: commands during busy ignored
        unlock(8'h80);
        bus_write(16'h5555, 16'h00AA);
        bus_write(16'h2AAA, 16'h0055);
        bus_write(16'h0008, 16'h0030);
        unlock(8'hA0);
        bus_write(16'h0020, 16'h0000);
        count_busy(n);
        model_wipe(SECT_W, 16'h0008);
        repeat (PROG_C) @(negedge clk);
        check("R9 no operation after busy", busy, 0);
        verify("R9 write during busy dropped", 16'h0020);
        verify("R5 sector erased", 16'h0009);
        verify("R5 outside sector kept", 16'h0005);

        // random mix
        for (int it = 0; it < 40; it++) begin
            int r;
            logic [ADDR_W-1:0] ra;
            r  = $urandom % 10;
            ra = ADDR_W'($urandom);
            if (r < 6) begin
                do_program(ra, DATA_W'($urandom));
            end else if (r == 6) begin
                do_erase(8'h30, ra);
                verify("R5 random sector erase", ra);
            end else if (r == 7) begin
                do_erase(8'h50, ra);
                verify("R6 random block erase", ra);
            end else begin
                bus_write(16'h5555, 16'h00AA);
                bus_write(16'h2AAA, 16'h0055);
                bus_write(16'h5555, 16'h0033);
                bus_write(ra, 16'h0000);
                @(negedge clk);
                check("R8 random abort no busy", busy, 0);
            end
            verify("R4 random readback", ADDR_W'($urandom));
        end

        // R6 directed block erase
        do_program(16'h0021, 16'h0000);
        do_program(16'h0001, 16'h0000);
        do_erase(8'h50, 16'h0030);
        verify("R6 block erased", 16'h0021);
        verify("R6 other block kept", 16'h0001);

        // R7: full erase requires 5555h
        unlock(8'h80);
        bus_write(16'h5555, 16'h00AA);
        bus_write(16'h2AAA, 16'h0055);
        bus_write(16'h1234, 16'h0010);
        @(negedge clk);
        check("R7 wrong address rejected", busy, 0);
        do_erase(8'h10, 16'h5555);
        for (int i = 0; i < DEPTH; i++) begin
            verify("R7 all words erased", ADDR_W'(i));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule